// File: doc/BRIEF.md
# Paged Non-Volatile Data Window Controller

This block sits between a processor's data bus and a byte-wide non-volatile array. The array shows up as one or two 64-byte pages mapped at data addresses 00h to 3Fh. An external bank-select value chooses which page is visible. Reads of the window behave like ordinary RAM reads. Writes to the window do not change the array directly. Instead they start a program cycle of fixed length, and a busy flag is set while that cycle runs.

A single control/status register at a configurable address gates all of this. It holds a programming-enable bit, an array-off bit and a parallel-collect bit. It also has a write-only commit strobe and a read-only busy flag. There are two write modes. In byte mode, every accepted window write programs one location. In parallel mode, writes are gathered into a one-row buffer of eight bytes, and a later commit strobe programs all gathered bytes of that row in a single cycle. The array is treated as off whenever the off bit is set, the stop input is high, or no page is selected.

Top module: `nvm_window_ctrl`

## Requirements
- R1: After reset the control register reads 40h (off set, all other bits clear), busy_o is 0, and every array location holds FFh.
- R2: The window covers addresses 00h-3Fh. bank_i=01 selects page 0 and bank_i=10 selects page 1. With bank_i=00 or 11, window reads return 00h and window writes have no effect.
- R3: A read takes effect at a clock edge: rdata_o shows the addressed value from that edge on. A valid window read returns the stored byte. A read of any other address, and any cycle without rd_i, gives 00h.
- R4: While the off bit (bit 6) is set or stop_i is high, window reads return 00h and window writes neither program nor collect.
- R5: A window write in byte mode while the enable bit (bit 0) is clear starts no program cycle and leaves the array unchanged.
- R6: In byte mode with enable set, a window write sets busy_o for exactly PROG_CYCLES cycles. Only the addressed location changes, and the new value is readable from the first cycle after busy_o clears.
- R7: While busy, window reads return 00h and window writes are dropped.
- R8: While busy, writes to the control register are ignored and a control register read returns 02h (only bit 1, busy).
- R9: Bits 3, 4, 5 and 7 of the control register always read 0, whatever is written to them. Bit 2 (collect) reads back as written.
- R10: In parallel mode (bit 2 set), the first accepted window write latches its page and row (row = address bits 5:3). Writes to any other row are dropped until commit or discard. A repeat write to the same byte replaces the gathered value.
- R11: A control write with bits 0, 2 and 3 all set, when at least one byte has been gathered, runs one program cycle of PROG_CYCLES cycles. Only the gathered bytes change, and the buffer then empties. If no byte has been gathered, or the enable bit is not among the written bits, no cycle starts.
- R12: A control write with bit 2 clear discards all gathered bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Data-space address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| bank_i | input | 2 | Page select: 01 page 0, 10 page 1, other values none |
| stop_i | input | 1 | Low-power stop, forces the array off |
| rdata_o | output | 8 | Registered read data |
| busy_o | output | 1 | Program cycle in progress |

## Verification
A stuck or mis-sized cycle counter appears on busy_o as a busy window of the wrong length, and that is visible on the very cycle it should have dropped. A wrong row latch or a wrong set of valid flags stays hidden until the commit. Once the commit's busy window has ended, it shows up on the first read of the affected row, as a byte that changed and should not have, or a byte that kept its old value. A gating fault in the off, stop, bank or busy logic shows up on the next window read as non-zero data. It also shows up as a busy pulse that should not have started.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam int ROW_BYTES  = 8;
  localparam int ROWS       = 8;
  localparam int COL_W      = $clog2(ROW_BYTES);
  localparam int ROW_W      = $clog2(ROWS);
  localparam int PAGE_BYTES = ROW_BYTES * ROWS;
  localparam int OFS_W      = COL_W + ROW_W;

  // control register bit positions
  localparam int B_EN   = 0;
  localparam int B_BUSY = 1;
  localparam int B_PAR  = 2;
  localparam int B_GO   = 3;
  localparam int B_OFF  = 6;

  localparam logic [7:0] ERASED = 8'hFF;

  typedef logic [7:0] byte_t;
  typedef logic [ROW_BYTES-1:0][7:0] row_data_t;

  typedef struct packed {
    logic en;
    logic par;
    logic off;
  } ctl_t;
endpackage

// File: rtl/nvm_ctl_reg.sv
module nvm_ctl_reg
  import nvm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  byte_t wdata_i,
  input  logic  busy_i,
  output ctl_t  ctl_o,
  output byte_t rd_o
);
  ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q.en  <= 1'b0;
      ctl_q.par <= 1'b0;
      ctl_q.off <= 1'b1;
    end else if (we_i && !busy_i) begin
      ctl_q.en  <= wdata_i[B_EN];
      ctl_q.par <= wdata_i[B_PAR];
      ctl_q.off <= wdata_i[B_OFF];
    end
  end

  always_comb begin
    rd_o = '0;
    if (busy_i) begin
      rd_o[B_BUSY] = 1'b1;
    end else begin
      rd_o[B_EN]  = ctl_q.en;
      rd_o[B_PAR] = ctl_q.par;
      rd_o[B_OFF] = ctl_q.off;
    end
  end

  assign ctl_o = ctl_q;

  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[7], wdata_i[5:3], wdata_i[1]};
endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
  parameter int PROG_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign done_o = busy_q && (cnt_q == CNT_W'(1));
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      cnt_q  <= CNT_W'(PROG_CYCLES);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (done_o) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/nvm_row_buf.sv
module nvm_row_buf
  import nvm_pkg::*;
#(
  parameter int PG_W = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  load_i,     // byte mode: single byte, replaces all
  input  logic                  collect_i,  // parallel mode: gather into row
  input  logic [PG_W-1:0]       page_i,
  input  logic [ROW_W-1:0]      row_i,
  input  logic [COL_W-1:0]      col_i,
  input  byte_t                 data_i,
  output logic [ROW_BYTES-1:0]  vld_o,
  output row_data_t             data_o,
  output logic [PG_W-1:0]       page_o,
  output logic [ROW_W-1:0]      row_o,
  output logic                  any_o
);
  logic [ROW_BYTES-1:0] vld_q;
  logic [PG_W-1:0]      page_q;
  logic [ROW_W-1:0]     row_q;
  logic                 same_row;
  logic                 take;

  assign any_o    = |vld_q;
  assign same_row = (page_q == page_i) && (row_q == row_i);
  assign take     = load_i || (collect_i && (!any_o || same_row));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      row_q  <= '0;
    end else if (take) begin
      page_q <= page_i;
      row_q  <= row_i;
    end
  end

  for (genvar c = 0; c < ROW_BYTES; c++) begin : g_col
    logic hit;
    assign hit = take && (col_i == COL_W'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[c] <= 1'b0;
      end else if (clr_i) begin
        vld_q[c] <= 1'b0;
      end else if (load_i) begin
        vld_q[c] <= hit;
      end else if (hit) begin
        vld_q[c] <= 1'b1;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  data_o[c] <= '0;
      else if (hit) data_o[c] <= data_i;
    end
  end

  assign vld_o  = vld_q;
  assign page_o = page_q;
  assign row_o  = row_q;
endmodule

// File: rtl/nvm_array.sv
module nvm_array
  import nvm_pkg::*;
#(
  parameter int PG_W = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [PG_W-1:0]      wpage_i,
  input  logic [ROW_W-1:0]     wrow_i,
  input  logic [ROW_BYTES-1:0] wbe_i,
  input  row_data_t            wdata_i,
  input  logic [PG_W-1:0]      rpage_i,
  input  logic [OFS_W-1:0]     rofs_i,
  output byte_t                rdata_o
);
  localparam int DEPTH = (2 ** PG_W) * PAGE_BYTES;

  byte_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= ERASED;
    end else if (we_i) begin
      for (int c = 0; c < ROW_BYTES; c++) begin
        if (wbe_i[c]) mem_q[{wpage_i, wrow_i, COL_W'(c)}] <= wdata_i[c];
      end
    end
  end

  assign rdata_o = mem_q[{rpage_i, rofs_i}];
endmodule

// File: rtl/nvm_window_ctrl.sv
module nvm_window_ctrl
  import nvm_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int NUM_PAGES   = 2,
  parameter int PROG_CYCLES = 16,
  parameter int CTL_ADDR    = 'h50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  input  logic [1:0]        bank_i,
  input  logic              stop_i,
  output logic [7:0]        rdata_o,
  output logic              busy_o
);
  localparam int PG_W = 1;

  ctl_t                 ctl_q;
  byte_t                ctl_rd;
  logic                 busy;
  logic                 done;
  logic                 win_hit, ctl_hit, page_ok, acc_ok;
  logic [PG_W-1:0]      page_idx;
  logic                 byte_start, collect, ctl_we, commit, buf_clr;
  logic [ROW_BYTES-1:0] buf_vld;
  row_data_t            buf_data;
  logic [PG_W-1:0]      buf_page;
  logic [ROW_W-1:0]     buf_row;
  logic                 buf_any;
  byte_t                arr_rd;

  assign win_hit = (addr_i[ADDR_W-1:OFS_W] == '0);
  assign ctl_hit = (addr_i == ADDR_W'(CTL_ADDR));

  if (NUM_PAGES > 1) begin : g_two_pages
    assign page_ok = (bank_i == 2'b01) || (bank_i == 2'b10);
  end else begin : g_one_page
    assign page_ok = (bank_i == 2'b01);
  end
  assign page_idx = PG_W'(bank_i[1]);

  assign acc_ok     = !ctl_q.off && !stop_i && page_ok && !busy;
  assign byte_start = wr_i && win_hit && acc_ok && ctl_q.en && !ctl_q.par;
  assign collect    = wr_i && win_hit && acc_ok && ctl_q.par;
  assign ctl_we     = wr_i && ctl_hit && !busy;
  assign commit     = ctl_we && wdata_i[B_GO] && wdata_i[B_PAR] && wdata_i[B_EN] && buf_any;
  assign buf_clr    = done || (ctl_we && !wdata_i[B_PAR]);

  nvm_ctl_reg u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctl_we),
    .wdata_i (wdata_i),
    .busy_i  (busy),
    .ctl_o   (ctl_q),
    .rd_o    (ctl_rd)
  );

  nvm_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (byte_start || commit),
    .busy_o  (busy),
    .done_o  (done)
  );

  nvm_row_buf #(.PG_W(PG_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (buf_clr),
    .load_i    (byte_start),
    .collect_i (collect),
    .page_i    (page_idx),
    .row_i     (addr_i[OFS_W-1:COL_W]),
    .col_i     (addr_i[COL_W-1:0]),
    .data_i    (wdata_i),
    .vld_o     (buf_vld),
    .data_o    (buf_data),
    .page_o    (buf_page),
    .row_o     (buf_row),
    .any_o     (buf_any)
  );

  nvm_array #(.PG_W(PG_W)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (done),
    .wpage_i (buf_page),
    .wrow_i  (buf_row),
    .wbe_i   (buf_vld),
    .wdata_i (buf_data),
    .rpage_i (page_idx),
    .rofs_i  (addr_i[OFS_W-1:0]),
    .rdata_o (arr_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (rd_i && ctl_hit) begin
      rdata_o <= ctl_rd;
    end else if (rd_i && win_hit && acc_ok) begin
      rdata_o <= arr_rd;
    end else begin
      rdata_o <= '0;
    end
  end

  assign busy_o = busy;
endmodule

// File: rtl/nvm_window_chk.sv
module nvm_window_chk #(
  parameter int ADDR_W      = 8,
  parameter int PROG_CYCLES = 16,
  parameter int CTL_ADDR    = 'h50
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic              stop_i,
  input logic [7:0]        rdata_o,
  input logic              busy_o,
  input logic              en_i,
  input logic              par_i,
  input logic              off_i
);
  localparam int RUN_W = $clog2(PROG_CYCLES + 2);

  logic win, ctl;
  logic [RUN_W-1:0] run_q;

  assign win = (addr_i < ADDR_W'(64));
  assign ctl = (addr_i == ADDR_W'(CTL_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + RUN_W'(1);
    else             run_q <= '0;
  end

  // R6: busy window never longer than PROG_CYCLES, and ends exactly there
  a_r6_busy_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_W'(PROG_CYCLES));
  a_r6_busy_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_q == RUN_W'(PROG_CYCLES));

  // R8: control register frozen and reads busy only
  a_r8_ctl_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && wr_i && ctl |=> $stable(en_i) && $stable(par_i) && $stable(off_i));
  a_r8_busy_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && rd_i && ctl |=> rdata_o == 8'h02);

  // R9: unused bits of the control register read zero
  a_r9_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && ctl |=> rdata_o[7] == 1'b0 && rdata_o[5:3] == 3'b000);

  // R4: stop forces reads to zero
  a_r4_stop_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && rd_i && win |=> rdata_o == 8'h00);

  // R7: reads while busy return zero
  a_r7_busy_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && rd_i && win |=> rdata_o == 8'h00);

  // R5: byte-mode write with enable clear starts nothing
  a_r5_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && wr_i && win && !en_i && !par_i |=> !busy_o);
endmodule

bind nvm_window_ctrl nvm_window_chk #(
  .ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES), .CTL_ADDR(CTL_ADDR)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .rd_i    (rd_i),
  .wr_i    (wr_i),
  .stop_i  (stop_i),
  .rdata_o (rdata_o),
  .busy_o  (busy_o),
  .en_i    (ctl_q.en),
  .par_i   (ctl_q.par),
  .off_i   (ctl_q.off)
);

// File: tb/tb_nvm_window_ctrl.sv
module tb_nvm_window_ctrl;
  localparam int PROG = 16;
  localparam logic [7:0] CTL = 8'h50;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] addr = '0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [1:0] bank = 2'b01;
  logic       stop = 1'b0;
  logic [7:0] rdata_o;
  logic       busy_o;

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  nvm_window_ctrl #(.ADDR_W(8), .NUM_PAGES(2), .PROG_CYCLES(PROG), .CTL_ADDR('h50)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .bank_i(bank), .stop_i(stop), .rdata_o(rdata_o), .busy_o(busy_o)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_mem [128];
  int         m_busy;
  logic       m_en, m_par, m_off;
  logic [7:0] m_rdata;
  int         q_col [$];
  logic [7:0] q_dat [$];
  int         q_row, q_pg;
  logic       mw, mok, mpg_ok;
  int         mpg, mpre_busy, midx;
  logic       mfound;

  always @(posedge clk) begin
    if (!rst_ni) begin
      for (int i = 0; i < 128; i++) m_mem[i] = 8'hFF;
      m_busy = 0; m_en = 0; m_par = 0; m_off = 1; m_rdata = 0;
      q_col.delete(); q_dat.delete();
    end else begin
      mpre_busy = m_busy;
      mw     = addr < 8'd64;
      mpg_ok = (bank == 2'b01) || (bank == 2'b10);
      mpg    = (bank == 2'b10) ? 1 : 0;
      mok    = !m_off && !stop && mpg_ok && (mpre_busy == 0);
      m_rdata = 8'h00;
      if (rd && addr == CTL)
        m_rdata = (mpre_busy != 0) ? 8'h02 : {1'b0, m_off, 3'b000, m_par, 1'b0, m_en};
      else if (rd && mw && mok)
        m_rdata = m_mem[mpg*64 + int'(addr)];
      if (mpre_busy != 0) begin
        if (mpre_busy == 1) begin
          foreach (q_col[k]) m_mem[q_pg*64 + q_row*8 + q_col[k]] = q_dat[k];
          q_col.delete(); q_dat.delete();
        end
        m_busy = mpre_busy - 1;
      end
      if (wr && mw && mok) begin
        if (!m_par) begin
          if (m_en) begin
            q_col.delete(); q_dat.delete();
            q_pg = mpg; q_row = int'(addr) / 8;
            q_col.push_back(int'(addr) % 8); q_dat.push_back(wdata);
            m_busy = PROG;
          end
        end else if (q_col.size() == 0 || (q_pg == mpg && q_row == int'(addr) / 8)) begin
          q_pg = mpg; q_row = int'(addr) / 8;
          mfound = 0;
          foreach (q_col[k]) if (q_col[k] == int'(addr) % 8) begin q_dat[k] = wdata; mfound = 1; end
          if (!mfound) begin q_col.push_back(int'(addr) % 8); q_dat.push_back(wdata); end
        end
      end
      if (wr && addr == CTL && mpre_busy == 0) begin
        midx = q_col.size();
        m_en = wdata[0]; m_par = wdata[2]; m_off = wdata[6];
        if (!wdata[2]) begin q_col.delete(); q_dat.delete(); end
        else if (wdata[3] && wdata[0] && midx > 0) m_busy = PROG;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_ni) begin
      checks++;
      if (rdata_o !== m_rdata || busy_o !== (m_busy != 0)) begin
        errors++;
        $display("FAIL %s model compare: rdata=%02h busy=%0b expected rdata=%02h busy=%0b",
                 cur_req, rdata_o, busy_o, m_rdata, m_busy != 0);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic op(input logic r, input logic w, input logic [7:0] a, input logic [7:0] d);
    rd = r; wr = w; addr = a; wdata = d;
    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    cur_req = req;
    op(1'b1, 1'b0, a, 8'h00);
    chk(req, rdata_o, exp);
  endtask

  task automatic wait_idle(input string req, input int exp_len);
    int n = 0;
    while (busy_o && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(req, 8'(n), 8'(exp_len));
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1", {7'd0, busy_o}, 8'h00);
    rd_chk("R1", CTL, 8'h40);
    // R4: off bit set after reset blocks the window
    rd_chk("R4", 8'h05, 8'h00);
    cur_req = "R4"; op(1'b0, 1'b1, 8'h05, 8'h12);
    chk("R4", {7'd0, busy_o}, 8'h00);

    cur_req = "R1"; op(1'b0, 1'b1, CTL, 8'h00);
    rd_chk("R1", 8'h05, 8'hFF);
    rd_chk("R3", 8'h60, 8'h00);

    // R5: enable clear
    cur_req = "R5"; op(1'b0, 1'b1, 8'h05, 8'h12);
    chk("R5", {7'd0, busy_o}, 8'h00);
    rd_chk("R5", 8'h05, 8'hFF);

    // R2: no page selected
    bank = 2'b00; rd_chk("R2", 8'h05, 8'h00);
    bank = 2'b11; rd_chk("R2", 8'h05, 8'h00);
    bank = 2'b01;

    // R6: byte program
    cur_req = "R6"; op(1'b0, 1'b1, CTL, 8'h01);
    op(1'b0, 1'b1, 8'h05, 8'hA5);
    chk("R6", {7'd0, busy_o}, 8'h01);
    rd_chk("R8", CTL, 8'h02);
    cur_req = "R8"; op(1'b0, 1'b1, CTL, 8'h40);
    rd_chk("R7", 8'h05, 8'h00);
    cur_req = "R7"; op(1'b0, 1'b1, 8'h06, 8'h77);
    cur_req = "R6"; wait_idle("R6", PROG - 4);
    rd_chk("R6", 8'h05, 8'hA5);
    rd_chk("R7", 8'h06, 8'hFF);
    rd_chk("R8", CTL, 8'h01);
    bank = 2'b10; rd_chk("R2", 8'h05, 8'hFF);

    // R2: page 1 program
    cur_req = "R2"; op(1'b0, 1'b1, 8'h3F, 8'h3C);
    wait_idle("R6", PROG);
    rd_chk("R2", 8'h3F, 8'h3C);
    bank = 2'b01; rd_chk("R2", 8'h3F, 8'hFF);

    // R9: reserved bits
    cur_req = "R9"; op(1'b0, 1'b1, CTL, 8'hF6);
    rd_chk("R9", CTL, 8'h44);
    cur_req = "R9"; op(1'b0, 1'b1, CTL, 8'h01);

    // R4: stop input
    stop = 1'b1;
    rd_chk("R4", 8'h05, 8'h00);
    cur_req = "R4"; op(1'b0, 1'b1, 8'h07, 8'h5A);
    chk("R4", {7'd0, busy_o}, 8'h00);
    stop = 1'b0;
    rd_chk("R4", 8'h07, 8'hFF);

    // R10/R11: parallel collect and commit
    cur_req = "R10"; op(1'b0, 1'b1, CTL, 8'h05);
    op(1'b0, 1'b1, 8'h10, 8'h11);
    op(1'b0, 1'b1, 8'h12, 8'h22);
    op(1'b0, 1'b1, 8'h1F, 8'h99);
    op(1'b0, 1'b1, 8'h12, 8'h33);
    chk("R10", {7'd0, busy_o}, 8'h00);
    rd_chk("R10", 8'h10, 8'hFF);
    cur_req = "R11"; op(1'b0, 1'b1, CTL, 8'h0D);
    chk("R11", {7'd0, busy_o}, 8'h01);
    wait_idle("R11", PROG);
    rd_chk("R11", 8'h10, 8'h11);
    rd_chk("R11", 8'h11, 8'hFF);
    rd_chk("R10", 8'h12, 8'h33);
    rd_chk("R10", 8'h1F, 8'hFF);

    // R11: commit with nothing gathered
    cur_req = "R11"; op(1'b0, 1'b1, CTL, 8'h0D);
    chk("R11", {7'd0, busy_o}, 8'h00);

    // R12: discard
    cur_req = "R12"; op(1'b0, 1'b1, 8'h20, 8'h55);
    op(1'b0, 1'b1, CTL, 8'h01);
    op(1'b0, 1'b1, CTL, 8'h0D);
    chk("R12", {7'd0, busy_o}, 8'h00);
    rd_chk("R12", 8'h20, 8'hFF);

    // R11: commit without enable, then with enable
    cur_req = "R11"; op(1'b0, 1'b1, CTL, 8'h04);
    op(1'b0, 1'b1, 8'h28, 8'h66);
    op(1'b0, 1'b1, CTL, 8'h0C);
    chk("R11", {7'd0, busy_o}, 8'h00);
    op(1'b0, 1'b1, CTL, 8'h0D);
    wait_idle("R11", PROG);
    rd_chk("R11", 8'h28, 8'h66);
    rd_chk("R3", 8'h05, 8'hA5);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule